// File: doc/BRIEF.md
# Instruction Byte Stream Assembler

This block sits between an instruction fetch path and a decoder for an 8-bit accumulator CPU. It accepts a stream of code bytes, one for each cycle in which `in_valid` is high. It groups them into whole instructions. The first byte of an instruction is either the single prefix value 0xCB or a plain opcode. From the opcode's octal fields the block works out whether zero, one or two operand bytes follow, and it collects them. When the last byte has been taken, it presents the complete instruction on a set of registered outputs for one cycle.

Each output record carries:
- the prefix flag,
- the opcode,
- the assembled operand,
- the total byte count,
- the address of the first byte,
- a flag for opcodes that do not exist on this CPU.

For the five relative-branch opcodes the record also carries the branch destination, already resolved. A 16-bit byte address counter advances with every accepted byte. It can be loaded from outside, for example after a taken branch.

Top module: `instr_stream_asm`

## Requirements
- R1: A byte of value 0xCB taken while no instruction is in progress is a prefix. The next byte is the opcode. The result has `out_prefixed`=1, `out_len`=2 and `out_imm`=0, whatever that opcode is.
- R2: These unprefixed opcodes take two operand bytes:
  - 0xC2, 0xCA, 0xD2, 0xDA, 0xC4, 0xCC, 0xD4, 0xDC;
  - 0xC3, 0xCD, 0x08;
  - 0x01, 0x11, 0x21, 0x31;
  - 0xEA, 0xFA.
  
  The result has `out_len`=3 and `out_imm`={second operand byte, first operand byte}.
- R3: These unprefixed opcodes take one operand byte:
  - 0x06, 0x0E, 0x16, 0x1E, 0x26, 0x2E, 0x36, 0x3E;
  - 0xC6, 0xCE, 0xD6, 0xDE, 0xE6, 0xEE, 0xF6, 0xFE;
  - 0x18, 0x20, 0x28, 0x30, 0x38;
  - 0xE0, 0xE8, 0xF0, 0xF8;
  - 0x10, whose operand byte is consumed and carries no meaning.
  
  The result has `out_len`=2 and `out_imm`={0x00, operand byte}.
- R4: Every other unprefixed opcode except 0xCB is a single byte, with `out_len`=1 and `out_imm`=0.
- R5: Opcodes 0xD3, 0xDB, 0xDD, 0xE3, 0xE4, 0xEB, 0xEC, 0xED, 0xF4, 0xFC and 0xFD give `out_illegal`=1 with `out_len`=1. All other instructions give `out_illegal`=0.
- R6: `out_valid` is high for exactly one cycle: the cycle after the last byte of an instruction is accepted. Cycles with `in_valid` low change nothing. Back-to-back single-byte instructions give `out_valid` high on consecutive cycles.
- R7: `out_addr` is the address of the instruction's first byte. The counter adds one for each accepted byte and wraps from 0xFFFF to 0x0000.
- R8: A cycle with `addr_ld` high loads the counter with `addr_ld_val`. A byte accepted in that same cycle is given address `addr_ld_val`, and the counter becomes `addr_ld_val`+1.
- R9: For opcodes 0x18, 0x20, 0x28, 0x30 and 0x38, `out_is_rel`=1. For these, `out_rel_tgt` = start address + 2 + the sign-extended operand byte, modulo 2^16. All other instructions give `out_is_rel`=0.
- R10: Reset does all of the following:
  - drops `out_valid`;
  - zeroes every output;
  - zeroes the address counter;
  - abandons any partial instruction, so the next byte is taken as a first byte.
- R11: The value 0xCB is a prefix only as a first byte. As an operand byte, or as the opcode after a prefix, it is ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A code byte is present this cycle |
| in_byte | input | 8 | Code byte |
| addr_ld | input | 1 | Load the byte address counter |
| addr_ld_val | input | ADDR_W | Value loaded into the counter |
| out_valid | output | 1 | One-cycle pulse: an instruction record is ready |
| out_prefixed | output | 1 | Instruction began with the 0xCB prefix |
| out_illegal | output | 1 | Opcode does not exist on this CPU |
| out_opcode | output | 8 | Opcode byte (the byte after the prefix when prefixed) |
| out_imm | output | 16 | Operand, high byte first; zero when there is none |
| out_len | output | 2 | Total instruction bytes, 1 to 3 |
| out_addr | output | ADDR_W | Address of the first byte |
| out_is_rel | output | 1 | Instruction is a relative branch |
| out_rel_tgt | output | ADDR_W | Resolved relative-branch destination |

## Verification
The hardest situation to reach is a relative branch whose start address, destination or counter crosses the 0xFFFF/0x0000 boundary. The counter gets there only after 65,536 bytes unless it is loaded. The bench therefore loads 0xFFFE and places a branch there. It also loads the counter in the same cycle as a byte, and sweeps all 256 displacements from a loaded base. A second case that is hard to reach is 0xCB showing up as operand data or as a prefixed opcode. The bench forces this with purpose-built operand bytes and a full sweep of prefixed opcodes.

// File: rtl/isa_asm_pkg.sv
package isa_asm_pkg;

  localparam int BYTE_W = 8;
  localparam int IMM_W  = 2 * BYTE_W;
  localparam int LEN_W  = 2;
  localparam int CNT_W  = 2;

  localparam logic [BYTE_W-1:0] PREFIX_BYTE = 8'hCB;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OPC    = 2'd1,
    ST_IMM_LO = 2'd2,
    ST_IMM_HI = 2'd3
  } asm_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] imm_cnt;
    logic             illegal;
    logic             rel;
  } op_class_t;

endpackage

// File: rtl/isa_len_decode.sv
module isa_len_decode
  import isa_asm_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output op_class_t         cls
);

  logic [1:0] fx;
  logic [2:0] fy;
  logic [2:0] fz;

  assign fx = opcode[7:6];
  assign fy = opcode[5:3];
  assign fz = opcode[2:0];

  always_comb begin
    cls = '0;
    unique case (fx)
      2'd0: begin
        unique case (fz)
          3'd0: begin
            if (fy == 3'd1) begin
              cls.imm_cnt = 2'd2;
            end else if (fy == 3'd2) begin
              cls.imm_cnt = 2'd1;
            end else if (fy >= 3'd3) begin
              cls.imm_cnt = 2'd1;
              cls.rel     = 1'b1;
            end
          end
          3'd1:    if (!fy[0]) cls.imm_cnt = 2'd2;
          3'd6:    cls.imm_cnt = 2'd1;
          default: cls = '0;
        endcase
      end
      2'd1, 2'd2: cls = '0;
      2'd3: begin
        unique case (fz)
          3'd0: if (fy >= 3'd4) cls.imm_cnt = 2'd1;
          3'd2: if (fy <= 3'd3 || fy == 3'd5 || fy == 3'd7) cls.imm_cnt = 2'd2;
          3'd3: begin
            if (fy == 3'd0) cls.imm_cnt = 2'd2;
            else if (fy >= 3'd2 && fy <= 3'd5) cls.illegal = 1'b1;
          end
          3'd4: begin
            if (fy <= 3'd3) cls.imm_cnt = 2'd2;
            else            cls.illegal = 1'b1;
          end
          3'd5: begin
            if (fy[0]) begin
              if (fy[2:1] == 2'd0) cls.imm_cnt = 2'd2;
              else                 cls.illegal = 1'b1;
            end
          end
          3'd6:    cls.imm_cnt = 2'd1;
          default: cls = '0;
        endcase
      end
      default: cls = '0;
    endcase
  end

  // R5
  always_comb begin
    illegal_no_imm_chk: assert (!(cls.illegal && cls.imm_cnt != '0));
  end

endmodule

// File: rtl/byte_addr_ctr.sv
module byte_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [ADDR_W-1:0] cnt_q
);

  logic [ADDR_W-1:0] cnt_d;

  assign byte_addr = ld ? ld_val : cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (ld || step) cnt_d = byte_addr + (step ? ADDR_W'(1) : ADDR_W'(0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld) |=> (cnt_q == $past(cnt_q) + ADDR_W'(1)));

  // R8
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val) + ADDR_W'($past(step))));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld) |=> $stable(cnt_q));

endmodule

// File: rtl/rel_target_calc.sv
module rel_target_calc
  import isa_asm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BYTE_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);

  localparam int EXT_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp[BYTE_W-1]}}, disp};
  assign target   = base + ADDR_W'(2) + disp_ext;

endmodule

// File: rtl/instr_stream_asm.sv
module instr_stream_asm
  import isa_asm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_ld_val,
  output logic              out_valid,
  output logic              out_prefixed,
  output logic              out_illegal,
  output logic [7:0]        out_opcode,
  output logic [15:0]       out_imm,
  output logic [1:0]        out_len,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_is_rel,
  output logic [ADDR_W-1:0] out_rel_tgt
);

  asm_state_e        st_q, st_d;
  logic [ADDR_W-1:0] start_q, start_d;
  logic              need2_q, need2_d;
  logic              rel_q, rel_d;
  logic [BYTE_W-1:0] lo_q, lo_d;

  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] cnt_q;
  op_class_t         dec_cls;

  logic              emit;
  logic              e_pfx;
  logic              e_ill;
  logic [BYTE_W-1:0] e_opc;
  logic [IMM_W-1:0]  e_imm;
  logic [LEN_W-1:0]  e_len;
  logic [ADDR_W-1:0] e_start;
  logic              e_rel;
  logic [ADDR_W-1:0] e_tgt;

  byte_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (in_valid),
    .ld        (addr_ld),
    .ld_val    (addr_ld_val),
    .byte_addr (cur_addr),
    .cnt_q     (cnt_q)
  );

  isa_len_decode u_dec (
    .opcode (in_byte),
    .cls    (dec_cls)
  );

  rel_target_calc #(.ADDR_W(ADDR_W)) u_rel (
    .base   (e_start),
    .disp   (in_byte),
    .target (e_tgt)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    start_d = start_q;
    need2_d = need2_q;
    rel_d   = rel_q;
    lo_d    = lo_q;
    emit    = 1'b0;
    e_pfx   = 1'b0;
    e_ill   = 1'b0;
    e_opc   = in_byte;
    e_imm   = '0;
    e_len   = LEN_W'(1);
    e_start = start_q;
    e_rel   = 1'b0;
    if (in_valid) begin
      unique case (st_q)
        ST_IDLE: begin
          start_d = cur_addr;
          e_start = cur_addr;
          if (in_byte == PREFIX_BYTE) begin
            st_d = ST_OPC;
          end else if (dec_cls.imm_cnt == '0) begin
            emit  = 1'b1;
            e_ill = dec_cls.illegal;
          end else begin
            st_d    = ST_IMM_LO;
            need2_d = (dec_cls.imm_cnt == CNT_W'(2));
            rel_d   = dec_cls.rel;
          end
        end
        ST_OPC: begin
          emit  = 1'b1;
          e_pfx = 1'b1;
          e_len = LEN_W'(2);
          st_d  = ST_IDLE;
        end
        ST_IMM_LO: begin
          if (need2_q) begin
            lo_d = in_byte;
            st_d = ST_IMM_HI;
          end else begin
            emit  = 1'b1;
            e_imm = {{BYTE_W{1'b0}}, in_byte};
            e_len = LEN_W'(2);
            e_rel = rel_q;
            st_d  = ST_IDLE;
          end
        end
        ST_IMM_HI: begin
          emit  = 1'b1;
          e_imm = {in_byte, lo_q};
          e_len = LEN_W'(3);
          st_d  = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // opcode is held from the first byte except for prefixed instructions
  logic [BYTE_W-1:0] opc_q, opc_d;
  always_comb begin
    opc_d = opc_q;
    if (in_valid && st_q == ST_IDLE) opc_d = in_byte;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= '0;
      need2_q <= 1'b0;
      rel_q   <= 1'b0;
      lo_q    <= '0;
      opc_q   <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      need2_q <= need2_d;
      rel_q   <= rel_d;
      lo_q    <= lo_d;
      opc_q   <= opc_d;
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_prefixed <= 1'b0;
      out_illegal  <= 1'b0;
      out_opcode   <= '0;
      out_imm      <= '0;
      out_len      <= '0;
      out_addr     <= '0;
      out_is_rel   <= 1'b0;
      out_rel_tgt  <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_prefixed <= e_pfx;
        out_illegal  <= e_ill;
        out_opcode   <= (st_q == ST_IDLE || st_q == ST_OPC) ? e_opc : opc_q;
        out_imm      <= e_imm;
        out_len      <= e_len;
        out_addr     <= e_start;
        out_is_rel   <= e_rel;
        out_rel_tgt  <= e_rel ? e_tgt : '0;
      end
    end
  end

  // R1
  prefix_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && in_valid && in_byte == PREFIX_BYTE) |=> (st_q == ST_OPC && !out_valid));

  // R6
  pulse_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R5
  illegal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_len == 2'd1 && !out_prefixed));

  // R2
  long_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 2'd3) |-> (!out_prefixed && !out_is_rel && !out_illegal));

  // R9
  rel_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_rel) |-> (out_len == 2'd2 && out_imm[15:8] == 8'h00));

  // R1
  prefix_no_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_prefixed) |-> (out_len == 2'd2 && out_imm == 16'h0000));

endmodule

// File: tb/sim_instr_stream_asm.sv
`timescale 1ns/1ps
module sim_instr_stream_asm;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        addr_ld;
  logic [15:0] addr_ld_val;
  logic        out_valid;
  logic        out_prefixed;
  logic        out_illegal;
  logic [7:0]  out_opcode;
  logic [15:0] out_imm;
  logic [1:0]  out_len;
  logic [15:0] out_addr;
  logic        out_is_rel;
  logic [15:0] out_rel_tgt;

  int          vecs;
  int          fails;
  logic [15:0] exp_addr;

  instr_stream_asm #(.ADDR_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .addr_ld(addr_ld), .addr_ld_val(addr_ld_val), .out_valid(out_valid),
    .out_prefixed(out_prefixed), .out_illegal(out_illegal), .out_opcode(out_opcode),
    .out_imm(out_imm), .out_len(out_len), .out_addr(out_addr),
    .out_is_rel(out_is_rel), .out_rel_tgt(out_rel_tgt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_imm(input logic [7:0] b);
    if ((b & 8'hE7) == 8'hC2 || (b & 8'hE7) == 8'hC4 || b == 8'hC3 || b == 8'hCD ||
        b == 8'h08 || (b & 8'hCF) == 8'h01 || b == 8'hEA || b == 8'hFA) return 2;
    if ((b & 8'hC7) == 8'h06 || (b & 8'hC7) == 8'hC6 || b == 8'h18 || b == 8'h20 ||
        b == 8'h28 || b == 8'h30 || b == 8'h38 || b == 8'hE0 || b == 8'hE8 ||
        b == 8'hF0 || b == 8'hF8 || b == 8'h10) return 1;
    return 0;
  endfunction

  function automatic logic ref_ill(input logic [7:0] b);
    case (b)
      8'hD3, 8'hDB, 8'hDD, 8'hE3, 8'hE4, 8'hEB, 8'hEC, 8'hED, 8'hF4, 8'hFC, 8'hFD: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ref_rel(input logic [7:0] b);
    return (b == 8'h18 || b == 8'h20 || b == 8'h28 || b == 8'h30 || b == 8'h38);
  endfunction

  // drives n bytes, then checks the record and the single-cycle pulse
  task automatic run_instr(input int n, input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input bit gap, input bit pfx, input string tag);
    logic [15:0] start;
    logic [15:0] eimm;
    logic [15:0] etgt;
    logic [7:0]  eop;
    logic        erel;
    start = exp_addr;
    eop   = pfx ? b1 : b0;
    erel  = pfx ? 1'b0 : ref_rel(b0);
    eimm  = (pfx || n == 1) ? 16'h0000 : (n == 2 ? {8'h00, b1} : {b2, b1});
    etgt  = start + 16'd2 + {{8{b1[7]}}, b1};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = (i == 0) ? b0 : (i == 1) ? b1 : b2;
      if (gap && i < n - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        chk({"R6 no early pulse ", tag}, 32'(out_valid), 32'd0);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk({"R6 pulse ", tag}, 32'(out_valid), 32'd1);
    chk({"R1 prefix flag ", tag}, 32'(out_prefixed), 32'(pfx));
    chk({tag, " opcode"}, 32'(out_opcode), 32'(eop));
    chk({tag, " length"}, 32'(out_len), 32'(n));
    chk({tag, " imm"}, 32'(out_imm), 32'(eimm));
    chk({"R5 illegal ", tag}, 32'(out_illegal), 32'(pfx ? 1'b0 : ref_ill(b0)));
    chk({"R7 start addr ", tag}, 32'(out_addr), 32'(start));
    chk({"R9 rel flag ", tag}, 32'(out_is_rel), 32'(erel));
    if (erel) chk({"R9 rel target ", tag}, 32'(out_rel_tgt), 32'(etgt));
    @(negedge clk);
    chk({"R6 one-cycle ", tag}, 32'(out_valid), 32'd0);
    exp_addr = start + 16'(n);
  endtask

  task automatic load_addr(input logic [15:0] v);
    @(negedge clk);
    addr_ld     = 1'b1;
    addr_ld_val = v;
    @(negedge clk);
    addr_ld  = 1'b0;
    exp_addr = v;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_addr = 16'h0000;
  endtask

  initial begin
    vecs = 0;
    fails = 0;
    in_valid = 1'b0;
    in_byte = 8'h00;
    addr_ld = 1'b0;
    addr_ld_val = 16'h0000;
    do_reset();

    // R10 reset state
    chk("R10 valid", 32'(out_valid), 32'd0);
    chk("R10 len", 32'(out_len), 32'd0);
    chk("R10 addr", 32'(out_addr), 32'd0);
    chk("R10 imm", 32'(out_imm), 32'd0);

    // unprefixed sweep (R2, R3, R4, R5)
    for (int op = 0; op < 256; op++) begin
      logic [7:0] b;
      int k;
      b = 8'(op);
      if (b == 8'hCB) continue;
      k = ref_imm(b);
      run_instr(k + 1, b, b ^ 8'h5A, ~b, b[0],
                1'b0, (k == 2) ? "R2" : (k == 1) ? "R3" : "R4");
    end

    // prefixed sweep (R1, R11 for 0xCB after prefix)
    for (int op = 0; op < 256; op++) begin
      run_instr(2, 8'hCB, 8'(op), 8'h00, op[0], 1'b1, (op == 8'hCB) ? "R11" : "R1");
    end

    // R11: 0xCB as operand data
    run_instr(2, 8'h06, 8'hCB, 8'h00, 1'b0, 1'b0, "R11 one-imm");
    run_instr(3, 8'hC3, 8'hCB, 8'hCB, 1'b0, 1'b0, "R11 two-imm");
    run_instr(1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R11 fresh");

    // R9 displacement sweep from a loaded base
    load_addr(16'h7F00);
    for (int d = 0; d < 256; d++) begin
      logic [7:0] jr;
      case (d % 5)
        0: jr = 8'h18;
        1: jr = 8'h20;
        2: jr = 8'h28;
        3: jr = 8'h30;
        default: jr = 8'h38;
      endcase
      run_instr(2, jr, 8'(d), 8'h00, 1'b0, 1'b0, "R9");
    end

    // R7/R9 wrap across 0xFFFF
    load_addr(16'hFFFE);
    run_instr(2, 8'h18, 8'h05, 8'h00, 1'b0, 1'b0, "R9 wrap");
    run_instr(1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R7 wrap");
    chk("R7 wrapped address", 32'(exp_addr), 32'h0001);

    // R8 load in the same cycle as a byte
    @(negedge clk);
    addr_ld     = 1'b1;
    addr_ld_val = 16'h1234;
    in_valid    = 1'b1;
    in_byte     = 8'h00;
    @(negedge clk);
    addr_ld  = 1'b0;
    in_valid = 1'b0;
    chk("R8 pulse", 32'(out_valid), 32'd1);
    chk("R8 addr of byte", 32'(out_addr), 32'h1234);
    exp_addr = 16'h1235;
    @(negedge clk);
    run_instr(1, 8'h3C, 8'h00, 8'h00, 1'b0, 1'b0, "R8 next");

    // R6 back-to-back single-byte instructions
    begin
      logic [15:0] a;
      a = exp_addr;
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = 8'h00;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (i == 3) in_valid = 1'b0;
        chk("R6 back-to-back pulse", 32'(out_valid), 32'd1);
        chk("R7 back-to-back addr", 32'(out_addr), 32'(a + 16'(i)));
      end
      @(negedge clk);
      chk("R6 back-to-back end", 32'(out_valid), 32'd0);
      exp_addr = a + 16'd4;
    end

    // R10 reset abandons a partial instruction
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = 8'hC3;
    @(negedge clk);
    in_byte  = 8'h11;
    @(negedge clk);
    in_valid = 1'b0;
    do_reset();
    chk("R10 valid after mid reset", 32'(out_valid), 32'd0);
    chk("R10 len after mid reset", 32'(out_len), 32'd0);
    run_instr(1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R10 fresh");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule